// File: doc/BRIEF.md
# Split Count-Up Timer with Two Independent Halves

The block is a memory-mapped timer made of two 32-bit count-up halves, a lower one and an upper one. Each half has its own counter, its own period and its own enable mode, which is off, one-shot or repeating. Each half also drives its own interrupt line. A shared global control word selects the timer mode and holds each half in reset or lets it run. Only the dual unchained 32-bit mode is implemented. In every other mode both halves keep their state and do not count.

Software reaches the block through a simple 32-bit bus with separate write and read strobes and a byte address. Read data is registered and appears one cycle after the read strobe. Software can write a counter or a period at any time. When a running half's counter equals its period, the half raises its interrupt for one cycle. A repeating half then restarts from zero. A one-shot half clears its own enable field and stops. A period of all ones turns a half into a free-running counter that wraps through the full range.

Top module: `dht_timer`

## Requirements
- R1: After synchronous reset, every counter, period, enable field and global control bit is zero, both interrupt outputs are low and `bus_rdata` is zero.
- R2: The register map uses these byte addresses: 0x10 lower counter, 0x14 upper counter, 0x18 lower period and 0x1C upper period. At 0x20 is the control word, with the lower enable field at bits 7:6 and the upper one at bits 23:22. At 0x24 is the global word: bit 0 is the lower run bit, bit 1 is the upper run bit and bits 3:2 are the timer mode. Unlisted bits read zero. Writes to any other address have no effect, and reads from them return zero. Read data appears on the cycle after the read strobe.
- R3: Address 0x00 always returns the identification word 0x44540001, and writes to it are ignored.
- R4: A half counts up by one per cycle only when all three hold: its run bit is 1, its enable field is non-zero and the global mode is 1. While its run bit is 0, its counter is forced to zero. In any other idle state, the counter holds its value.
- R5: In enable code 2 (repeating, and likewise code 3), a running half whose counter equals its period pulses its interrupt on the next cycle. On that same edge, the counter returns to zero and counting continues. With a period of zero, the interrupt stays high every cycle.
- R6: In enable code 1 (one-shot), on a match the interrupt pulses once, the hardware writes the half's enable field to 0 and the counter holds at the period value.
- R7: With a period of 0xFFFFFFFF, the counter wraps from all ones to zero and raises an interrupt on each wrap.
- R8: A software write to a counter takes priority over counting, and a match in that cycle gives no interrupt. A software write to the control word takes priority over the one-shot hardware clear.
- R9: The two halves are independent: a period, counter, mode or run-bit change on one half does not alter the other half's count or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_lo | output | 1 | Lower-half interrupt pulse |
| irq_hi | output | 1 | Upper-half interrupt pulse |

## Verification
Counting is tried in several settings:
- A short repeating period, which separates restart-at-zero from restart-at-one.
- A zero period, which shows whether the interrupt stays high every cycle.
- A one-shot on the other half, which shows whether the enable field clears itself and the counter holds.
- A counter preloaded just below all ones, which shows a true wrap rather than saturation.

Changing the global mode and dropping the run bit in the middle of a count separate holding from clearing. Writing a counter in the middle of a run, and overwriting the control word during a one-shot, expose the priority order. Register reads, writes to unmapped addresses and a write to the identification word verify the field positions and the read-only identification word.

// File: rtl/dht_pkg.sv
package dht_pkg;
  localparam int OFS_ID     = 'h00;
  localparam int OFS_CNT_LO = 'h10;
  localparam int OFS_CNT_HI = 'h14;
  localparam int OFS_PRD_LO = 'h18;
  localparam int OFS_PRD_HI = 'h1C;
  localparam int OFS_CTL    = 'h20;
  localparam int OFS_GCTL   = 'h24;

  localparam int EN_LSB_LO = 6;
  localparam int EN_LSB_HI = 22;

  localparam logic [1:0] EN_OFF  = 2'd0;
  localparam logic [1:0] EN_ONCE = 2'd1;
  localparam logic [1:0] GM_DUAL32 = 2'd1;

  localparam int NUM_HALVES = 2;
  localparam int GCTL_W = 4;
endpackage

// File: rtl/dht_half.sv
module dht_half
  import dht_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en_i,
  input  logic              rel_i,
  input  logic              cnt_wr_i,
  input  logic              prd_wr_i,
  input  logic              mode_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        mode_wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] prd_o,
  output logic [1:0]        mode_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] cnt_q, prd_q;
  logic [1:0]        mode_q;
  logic              irq_q;
  logic              run, hit;

  assign run = rel_i && run_en_i && (mode_q != EN_OFF);
  assign hit = run && (cnt_q == prd_q) && !cnt_wr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      prd_q  <= '0;
      mode_q <= EN_OFF;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= hit;
      if (prd_wr_i) prd_q <= wdata_i;
      if (!rel_i)          cnt_q <= '0;
      else if (cnt_wr_i)   cnt_q <= wdata_i;
      else if (hit)        cnt_q <= (mode_q == EN_ONCE) ? cnt_q : '0;
      else if (run)        cnt_q <= cnt_q + ONE;
      if (mode_wr_i)                        mode_q <= mode_wdata_i;
      else if (hit && (mode_q == EN_ONCE))  mode_q <= EN_OFF;
    end
  end

  assign cnt_o  = cnt_q;
  assign prd_o  = prd_q;
  assign mode_o = mode_q;
  assign irq_o  = irq_q;

  // R4: a half whose run bit is low is cleared on the next edge
  p_clear_when_held_r4: assert property (@(posedge clk) disable iff (rst)
    !rel_i |=> (cnt_o == '0));

  // R4: a half that is released but not running keeps its count
  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (rel_i && !(run_en_i && mode_o != EN_OFF) && !cnt_wr_i) |=> $stable(cnt_o));

  // R4: a running half below its match steps by exactly one
  p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
    (run && (cnt_o != prd_o) && !cnt_wr_i) |=> (cnt_o == $past(cnt_o) + ONE));

  // R5: a match while running raises the interrupt one cycle later
  p_irq_on_match_r5: assert property (@(posedge clk) disable iff (rst)
    (run && (cnt_o == prd_o) && !cnt_wr_i) |=> irq_o);

  // R6: a one-shot match leaves the enable field off unless software rewrites it
  p_oneshot_off_r6: assert property (@(posedge clk) disable iff (rst)
    (hit && (mode_o == EN_ONCE) && !mode_wr_i) |=> (mode_o == EN_OFF));
endmodule

// File: rtl/dht_rdmux.sv
module dht_rdmux
  import dht_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 6,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h4454_0001
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] cnt_lo_i,
  input  logic [DATA_W-1:0] cnt_hi_i,
  input  logic [DATA_W-1:0] prd_lo_i,
  input  logic [DATA_W-1:0] prd_hi_i,
  input  logic [1:0]        mode_lo_i,
  input  logic [1:0]        mode_hi_i,
  input  logic [GCTL_W-1:0] gctl_i,
  output logic [DATA_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    case (addr_i)
      ADDR_W'(OFS_ID):     word_o = ID_VALUE;
      ADDR_W'(OFS_CNT_LO): word_o = cnt_lo_i;
      ADDR_W'(OFS_CNT_HI): word_o = cnt_hi_i;
      ADDR_W'(OFS_PRD_LO): word_o = prd_lo_i;
      ADDR_W'(OFS_PRD_HI): word_o = prd_hi_i;
      ADDR_W'(OFS_CTL): begin
        word_o[EN_LSB_LO +: 2] = mode_lo_i;
        word_o[EN_LSB_HI +: 2] = mode_hi_i;
      end
      ADDR_W'(OFS_GCTL):   word_o[GCTL_W-1:0] = gctl_i;
      default:             word_o = '0;
    endcase
  end
endmodule

// File: rtl/dht_timer.sv
module dht_timer
  import dht_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 6,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h4454_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam logic [ADDR_W-1:0] CNT_OFS [NUM_HALVES] = '{ADDR_W'(OFS_CNT_LO), ADDR_W'(OFS_CNT_HI)};
  localparam logic [ADDR_W-1:0] PRD_OFS [NUM_HALVES] = '{ADDR_W'(OFS_PRD_LO), ADDR_W'(OFS_PRD_HI)};
  localparam int                EN_LSB  [NUM_HALVES] = '{EN_LSB_LO, EN_LSB_HI};

  logic [GCTL_W-1:0] gctl_q;
  logic [DATA_W-1:0] rdata_q, rd_word;
  logic [DATA_W-1:0] cnt  [NUM_HALVES];
  logic [DATA_W-1:0] prd  [NUM_HALVES];
  logic [1:0]        mode [NUM_HALVES];
  logic [NUM_HALVES-1:0] irq;
  logic run_en, ctl_wr;

  assign run_en = (gctl_q[3:2] == GM_DUAL32);
  assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));

  always_ff @(posedge clk) begin
    if (rst) gctl_q <= '0;
    else if (bus_wr && (bus_addr == ADDR_W'(OFS_GCTL))) gctl_q <= bus_wdata[GCTL_W-1:0];
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    dht_half #(.DATA_W(DATA_W)) i_half (
      .clk         (clk),
      .rst         (rst),
      .run_en_i    (run_en),
      .rel_i       (gctl_q[h]),
      .cnt_wr_i    (bus_wr && (bus_addr == CNT_OFS[h])),
      .prd_wr_i    (bus_wr && (bus_addr == PRD_OFS[h])),
      .mode_wr_i   (ctl_wr),
      .wdata_i     (bus_wdata),
      .mode_wdata_i(bus_wdata[EN_LSB[h] +: 2]),
      .cnt_o       (cnt[h]),
      .prd_o       (prd[h]),
      .mode_o      (mode[h]),
      .irq_o       (irq[h])
    );
  end

  dht_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) i_rdmux (
    .addr_i   (bus_addr),
    .cnt_lo_i (cnt[0]),
    .cnt_hi_i (cnt[1]),
    .prd_lo_i (prd[0]),
    .prd_hi_i (prd[1]),
    .mode_lo_i(mode[0]),
    .mode_hi_i(mode[1]),
    .gctl_i   (gctl_q),
    .word_o   (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;
  assign irq_lo    = irq[0];
  assign irq_hi    = irq[1];

  // R3: the identification word reads back constant
  p_id_const_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_ID)) |=> (bus_rdata == ID_VALUE));

  // R2: an unmapped address in the gap reads zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'('h08)) |=> (bus_rdata == '0));

  // R2: without a read strobe the read data holds
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_dht_timer.sv
module test_dht_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;

  int checks = 0, errors = 0, cycles = 0;
  bit running = 1'b0;
  string cur_req = "R1";

  // reference state
  logic [31:0] m_cnt [2];
  logic [31:0] m_prd [2];
  logic [1:0]  m_mode [2];
  logic        m_irq [2];
  logic [3:0]  m_g;
  logic [31:0] m_rdata;
  bit          m_rdv;

  dht_timer i_dht_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi));

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int h = 0; h < 2; h++) begin
        m_cnt[h] = 0; m_prd[h] = 0; m_mode[h] = 0; m_irq[h] = 0;
      end
      m_g = 0; m_rdata = 0; m_rdv = 0;
    end else begin
      bit run [2];
      bit hit [2];
      bit cwr;
      if (bus_rd) begin
        m_rdv = 1;
        case (bus_addr)
          6'h00: m_rdata = 32'h4454_0001;
          6'h10: m_rdata = m_cnt[0];
          6'h14: m_rdata = m_cnt[1];
          6'h18: m_rdata = m_prd[0];
          6'h1C: m_rdata = m_prd[1];
          6'h20: m_rdata = {8'h0, m_mode[1], 14'h0, m_mode[0], 6'h0};
          6'h24: m_rdata = {28'h0, m_g};
          default: m_rdata = 0;
        endcase
      end
      for (int h = 0; h < 2; h++) begin
        cwr = bus_wr && (bus_addr == (h == 0 ? 6'h10 : 6'h14));
        run[h] = m_g[h] && (m_g[3:2] == 2'd1) && (m_mode[h] != 0);
        hit[h] = run[h] && (m_cnt[h] == m_prd[h]) && !cwr;
        m_irq[h] = hit[h];
        if (!m_g[h]) m_cnt[h] = 0;
        else if (cwr) m_cnt[h] = bus_wdata;
        else if (hit[h]) m_cnt[h] = (m_mode[h] == 1) ? m_cnt[h] : 0;
        else if (run[h]) m_cnt[h] = m_cnt[h] + 1;
        if (bus_wr && bus_addr == (h == 0 ? 6'h18 : 6'h1C)) m_prd[h] = bus_wdata;
        if (bus_wr && bus_addr == 6'h20) m_mode[h] = (h == 0) ? bus_wdata[7:6] : bus_wdata[23:22];
        else if (hit[h] && m_mode[h] == 1) m_mode[h] = 0;
      end
      if (bus_wr && bus_addr == 6'h24) m_g = bus_wdata[3:0];
    end
  end

  always @(negedge clk) begin
    if (running && !rst) begin
      chk(cur_req, "irq_lo", {31'h0, irq_lo}, {31'h0, m_irq[0]});
      chk(cur_req, "irq_hi", {31'h0, irq_hi}, {31'h0, m_irq[1]});
      if (m_rdv) begin
        chk(cur_req, "rdata", bus_rdata, m_rdata);
        m_rdv = 0;
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state at the ports
    chk("R1", "rdata after reset", bus_rdata, 32'h0);
    chk("R1", "irq_lo after reset", {31'h0, irq_lo}, 32'h0);
    chk("R1", "irq_hi after reset", {31'h0, irq_hi}, 32'h0);
    running = 1;
    rd(6'h10); rd(6'h14); rd(6'h18); rd(6'h1C); rd(6'h20); rd(6'h24);

    cur_req = "R3";
    rd(6'h00); wr(6'h00, 32'hFFFF_FFFF); rd(6'h00);

    cur_req = "R2";
    wr(6'h08, 32'h1234_5678); wr(6'h2C, 32'hFFFF_FFFF); wr(6'h11, 32'h5);
    rd(6'h08); rd(6'h2C); rd(6'h11); rd(6'h10); rd(6'h18);
    wr(6'h20, 32'hFFFF_FFFF); rd(6'h20);
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h24);
    wr(6'h24, 32'h0); wr(6'h20, 32'h0); rd(6'h20);

    cur_req = "R5";
    wr(6'h18, 32'd5);
    wr(6'h20, 32'h0000_0080);
    wr(6'h24, 32'h7);
    idle(20); rd(6'h10); idle(9); rd(6'h10);

    cur_req = "R4";
    wr(6'h24, 32'h3);
    rd(6'h10); idle(5); rd(6'h10);
    wr(6'h24, 32'h7); idle(4); rd(6'h10);

    cur_req = "R6";
    wr(6'h1C, 32'd3);
    wr(6'h20, 32'h0040_0080);
    idle(12); rd(6'h20); rd(6'h14);

    cur_req = "R8";
    wr(6'h20, 32'h0040_0080);
    idle(1); wr(6'h20, 32'h0040_0080);
    idle(6); rd(6'h20);
    wr(6'h10, 32'd2); rd(6'h10);
    wr(6'h10, 32'd5); wr(6'h10, 32'd5); rd(6'h10); idle(8);

    cur_req = "R7";
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h10, 32'hFFFF_FFFC);
    idle(8); rd(6'h10);

    cur_req = "R9";
    wr(6'h1C, 32'd4); wr(6'h20, 32'h0080_0080);
    wr(6'h18, 32'd3); wr(6'h10, 32'd0);
    idle(12); wr(6'h24, 32'h6); idle(4); rd(6'h10); rd(6'h14);
    wr(6'h24, 32'h5); idle(6); rd(6'h10); rd(6'h14);

    cur_req = "R5";
    wr(6'h24, 32'h7); wr(6'h18, 32'd0); wr(6'h10, 32'd0);
    idle(6); rd(6'h10);

    cur_req = "R4";
    wr(6'h24, 32'h4); rd(6'h10); rd(6'h14); idle(3);

    running = 0;
    finish_run();
  end
endmodule